// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer for a 16-bit Word Machine

This block is the control unit of a small 16-bit processor. It fetches the first word of each instruction, decides whether it is a two-operand (basic) instruction or a single-operand (extended) one, then reads any extra operand words at consecutive program addresses. It resolves the first operand before the second and executes the operation. It holds the eight general registers, the stack pointer, the overflow register and the program counter. Results are written back to a register or to data memory.

Each instruction takes a fixed number of cycles. That number comes from its opcode class, plus one cycle for every extra word an operand needs. A conditional test that fails costs one more cycle, which the sequencer uses to read the next instruction's first word and jump past its full length. The only extended operation is a subroutine call, which pushes the return address and jumps. The memory side is combinational: one read-only instruction port, two data read ports for the two operands, and one data write port that commits at the clock edge. The `insn_start` output marks every cycle that fetches the first word of an instruction, so the stall pattern is visible at the ports.

Top module: `cpu16_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, `insn_start` is high, `imem_addr` is 0x0000 and `dmem_we` is low. All registers, the stack pointer and the overflow register reset to zero.
- R2: Instruction word layout: bits 3:0 hold the opcode, bits 9:4 hold operand a and bits 15:10 hold operand b. Opcode 0 is extended: bits 9:4 are the sub-operation and bits 15:10 are its only operand. Operand a is resolved, including its stack pointer effect, before operand b. Opcode values: 1 SET, 2 ADD, 3 SUB, 4 MUL, 5 DIV, 6 MOD, 7 SHL, 8 SHR, 9 AND, A OR, B XOR, C test-equal, D test-unequal, E test-greater, F test-any-bit.
- R3: Base cycle cost is 1 for SET/AND/OR/XOR, 2 for ADD/SUB/MUL/SHL/SHR, and 3 for DIV/MOD. The next `insn_start` follows after exactly that many cycles plus the operand costs.
- R4: Operand modes 0x10-0x17 (word plus register, indirect), 0x1E (indirect word) and 0x1F (literal word) each read one extra word at the incrementing PC and add one cycle. Modes 0x00-0x07 are registers, 0x08-0x0F are indirect through a register, 0x1B is SP, 0x1C is PC, 0x1D is the overflow register, and 0x20-0x3F are the literals 0-31.
- R5: A test costs 2 cycles plus operand costs when it holds. When it fails it costs one cycle more, and the whole following instruction, including its extra words, is skipped without any write.
- R6: Extended sub-operation 0x01 (call) costs 2 plus operand cost. It writes the address of the next instruction to memory at SP-1, decrements SP, and the next fetch is at the operand value.
- R7: A write whose destination is a literal (mode 0x1F or 0x20-0x3F) changes nothing. Neither memory nor any register is touched.
- R8: Overflow register: ADD sets it to 1 on a carry and 0 otherwise. SUB sets it to 0xFFFF on a borrow and 0 otherwise. MUL sets it to the high product word. DIV sets it to ((a<<16)/b) low word. SHL sets it to the bits shifted out above bit 15. SHR sets it to ((a<<16)>>b) low word. DIV by zero gives result 0 and overflow 0.
- R9: Mode 0x1A (push) addresses SP-1 and decrements SP. Mode 0x18 (pop) addresses SP and then increments it. Mode 0x19 addresses SP without changing it.
- R10: When an instruction writes PC, the next `insn_start` fetches at the written value.
- R11: Extended sub-operations other than 0x01 do nothing and cost 1 cycle plus operand cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Instruction read address (current PC) |
| imem_rdata | input | 16 | Instruction word at `imem_addr`, combinational |
| dmem_raddr_a | output | 16 | Data read address for operand a |
| dmem_rdata_a | input | 16 | Data word at `dmem_raddr_a` |
| dmem_raddr_b | output | 16 | Data read address for operand b |
| dmem_rdata_b | input | 16 | Data word at `dmem_raddr_b` |
| dmem_we | output | 1 | Data write enable, committed at the clock edge |
| dmem_waddr | output | 16 | Data write address |
| dmem_wdata | output | 16 | Data write value |
| insn_start | output | 1 | High in the cycle that fetches an instruction's first word |

## Verification
The bench runs one program. It mixes single-word instructions, instructions with one and with two extra words, and every cost class including divide. Comparing the cycle of each `insn_start` against its expected cycle separates the cost classes, the cost of extra words, and the extra cycle of a failed test. A failed test is followed by a three-word instruction: the next fetch address shows whether the whole length was skipped, and any stray write shows whether the skipped instruction executed. The push, call and two pops check operand ordering and return-address values through the data write port. The stored overflow values after add, divide, divide by zero, shift and subtract tell each overflow rule apart. A write to a literal destination with a word address, and a reserved extended operation, must leave no memory write behind.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int WORD_W   = 16;
    localparam int NREG     = 8;
    localparam int REG_IDX_W = $clog2(NREG);
    localparam int MODE_W   = 6;
    localparam int COST_W   = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MODE_W-1:0] mode_t;

    typedef enum logic [3:0] {
        OP_EXT = 4'h0, OP_SET = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
        OP_MUL = 4'h4, OP_DIV = 4'h5, OP_MOD = 4'h6, OP_SHL = 4'h7,
        OP_SHR = 4'h8, OP_AND = 4'h9, OP_BOR = 4'hA, OP_XOR = 4'hB,
        OP_IFE = 4'hC, OP_IFN = 4'hD, OP_IFG = 4'hE, OP_IFB = 4'hF
    } opc_e;

    localparam mode_t EXT_CALL = 6'h01;

    typedef enum logic [2:0] {K_REG, K_MEM, K_SP, K_PC, K_OVF, K_LIT} kind_e;

    typedef enum logic [1:0] {ST_FETCH, ST_RUN, ST_SKIP} st_e;

    typedef struct packed {
        kind_e                kind;
        logic [REG_IDX_W-1:0] idx;
        word_t                addr;
        word_t                val;
        word_t                sp_next;
    } opnd_t;

    // An operand mode that consumes one extra instruction word
    function automatic logic takes_word(input mode_t m);
        return (m[5:3] == 3'b010) || (m == 6'h1E) || (m == 6'h1F);
    endfunction

    function automatic logic [1:0] extra_words(input word_t ir);
        if (ir[3:0] == 4'h0)
            return {1'b0, takes_word(ir[15:10])};
        return 2'(takes_word(ir[9:4])) + 2'(takes_word(ir[15:10]));
    endfunction

    function automatic logic [COST_W-1:0] base_cost(input word_t ir);
        case (opc_e'(ir[3:0]))
            OP_SET, OP_AND, OP_BOR, OP_XOR:         return 3'd1;
            OP_ADD, OP_SUB, OP_MUL, OP_SHL, OP_SHR: return 3'd2;
            OP_DIV, OP_MOD:                         return 3'd3;
            OP_IFE, OP_IFN, OP_IFG, OP_IFB:         return 3'd2;
            default: return (ir[9:4] == EXT_CALL) ? 3'd2 : 3'd1;
        endcase
    endfunction

    function automatic logic is_test(input opc_e op);
        return op inside {OP_IFE, OP_IFN, OP_IFG, OP_IFB};
    endfunction

endpackage

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
(
    input  opc_e  op,
    input  word_t x,
    input  word_t y,
    output word_t res,
    output logic  ovf_we,
    output word_t ovf,
    output logic  cond
);
    logic [2*WORD_W-1:0] wide;

    always_comb begin
        res    = y;
        ovf_we = 1'b0;
        ovf    = '0;
        cond   = 1'b0;
        wide   = '0;
        case (op)
            OP_ADD: begin
                wide   = {{WORD_W{1'b0}}, x} + {{WORD_W{1'b0}}, y};
                res    = wide[WORD_W-1:0];
                ovf_we = 1'b1;
                ovf    = wide[WORD_W] ? word_t'(1) : '0;
            end
            OP_SUB: begin
                res    = x - y;
                ovf_we = 1'b1;
                ovf    = (y > x) ? '1 : '0;
            end
            OP_MUL: begin
                wide   = {{WORD_W{1'b0}}, x} * {{WORD_W{1'b0}}, y};
                res    = wide[WORD_W-1:0];
                ovf_we = 1'b1;
                ovf    = wide[2*WORD_W-1:WORD_W];
            end
            OP_DIV: begin
                ovf_we = 1'b1;
                if (y == '0) begin
                    res = '0;
                    ovf = '0;
                end else begin
                    res  = x / y;
                    wide = {x, {WORD_W{1'b0}}} / {{WORD_W{1'b0}}, y};
                    ovf  = wide[WORD_W-1:0];
                end
            end
            OP_MOD: res = (y == '0) ? '0 : x % y;
            OP_SHL: begin
                wide   = {{WORD_W{1'b0}}, x} << y;
                res    = wide[WORD_W-1:0];
                ovf_we = 1'b1;
                ovf    = wide[2*WORD_W-1:WORD_W];
            end
            OP_SHR: begin
                wide   = {x, {WORD_W{1'b0}}} >> y;
                res    = x >> y;
                ovf_we = 1'b1;
                ovf    = wide[WORD_W-1:0];
            end
            OP_AND: res = x & y;
            OP_BOR: res = x | y;
            OP_XOR: res = x ^ y;
            OP_IFE: cond = (x == y);
            OP_IFN: cond = (x != y);
            OP_IFG: cond = (x > y);
            OP_IFB: cond = ((x & y) != '0);
            default: res = y;
        endcase
    end
endmodule

// File: rtl/seq_operand.sv
module seq_operand
    import seq_pkg::*;
(
    input  mode_t mode,
    input  word_t reg_val,
    input  word_t sp,
    input  word_t pc,
    input  word_t ovf,
    input  word_t nxt,
    output opnd_t res
);
    always_comb begin
        res.kind    = K_LIT;
        res.idx     = mode[REG_IDX_W-1:0];
        res.addr    = '0;
        res.val     = word_t'(mode[4:0]);
        res.sp_next = sp;
        if (mode[5]) begin
            res.kind = K_LIT;
        end else begin
            case (mode[4:3])
                2'b00: begin res.kind = K_REG; res.val  = reg_val;       end
                2'b01: begin res.kind = K_MEM; res.addr = reg_val;       end
                2'b10: begin res.kind = K_MEM; res.addr = nxt + reg_val; end
                default: begin
                    case (mode[2:0])
                        3'd0: begin res.kind = K_MEM; res.addr = sp; res.sp_next = sp + 1'b1; end
                        3'd1: begin res.kind = K_MEM; res.addr = sp; end
                        3'd2: begin res.kind = K_MEM; res.addr = sp - 1'b1; res.sp_next = sp - 1'b1; end
                        3'd3: begin res.kind = K_SP;  res.val = sp;  end
                        3'd4: begin res.kind = K_PC;  res.val = pc;  end
                        3'd5: begin res.kind = K_OVF; res.val = ovf; end
                        3'd6: begin res.kind = K_MEM; res.addr = nxt; end
                        default: begin res.kind = K_LIT; res.val = nxt; end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/cpu16_sequencer.sv
module cpu16_sequencer
    import seq_pkg::*;
#(
    parameter word_t RESET_PC = '0,
    parameter word_t RESET_SP = '0
) (
    input  logic  clk,
    input  logic  rst,
    output word_t imem_addr,
    input  word_t imem_rdata,
    output word_t dmem_raddr_a,
    input  word_t dmem_rdata_a,
    output word_t dmem_raddr_b,
    input  word_t dmem_rdata_b,
    output logic  dmem_we,
    output word_t dmem_waddr,
    output word_t dmem_wdata,
    output logic  insn_start
);
    st_e               st;
    word_t             pc, sp, ovf;
    word_t             regs [NREG];
    word_t             ir_q, nwa_q, nwb_q;
    logic [COST_W-1:0] left;
    logic              pend_a, pend_b;

    // Decode of the current instruction word (live during the fetch cycle)
    logic              fetching, ext, need_a, need_b, word_now, last, exec, call, test_op;
    word_t             ir, nwa, nwb, pc_cur, va, vb;
    opc_e              op;
    mode_t             mode_a, mode_b;
    logic [COST_W-1:0] cost;
    opnd_t             oa, ob;
    word_t             alu_res, alu_ovf;
    logic              alu_ovf_we, alu_cond;

    always_comb begin
        fetching = (st == ST_FETCH);
        ir       = fetching ? imem_rdata : ir_q;
        op       = opc_e'(ir[3:0]);
        ext      = (op == OP_EXT);
        mode_a   = ext ? ir[15:10] : ir[9:4];
        mode_b   = ir[15:10];
        need_a   = takes_word(mode_a);
        need_b   = !ext && takes_word(mode_b);
        cost     = base_cost(ir) + COST_W'(need_a) + COST_W'(need_b);
        word_now = fetching || (st == ST_RUN && (pend_a || pend_b));
        last     = fetching ? (cost == 3'd1) : (st == ST_RUN && left == 3'd1);
        exec     = last && !rst;
        call     = ext && (ir[9:4] == EXT_CALL);
        test_op  = is_test(op);
        nwa      = (st == ST_RUN && pend_a) ? imem_rdata : nwa_q;
        nwb      = (st == ST_RUN && !pend_a && pend_b) ? imem_rdata : nwb_q;
        pc_cur   = pc + word_t'(word_now);
    end

    seq_operand u_opa (
        .mode(mode_a), .reg_val(regs[mode_a[REG_IDX_W-1:0]]), .sp(sp),
        .pc(pc_cur), .ovf(ovf), .nxt(nwa), .res(oa)
    );

    // Operand b sees the stack pointer as left by operand a
    seq_operand u_opb (
        .mode(mode_b), .reg_val(regs[mode_b[REG_IDX_W-1:0]]), .sp(oa.sp_next),
        .pc(pc_cur), .ovf(ovf), .nxt(nwb), .res(ob)
    );

    assign dmem_raddr_a = oa.addr;
    assign dmem_raddr_b = ob.addr;
    assign va = (oa.kind == K_MEM) ? dmem_rdata_a : oa.val;
    assign vb = (ob.kind == K_MEM) ? dmem_rdata_b : ob.val;

    seq_alu u_alu (
        .op(op), .x(va), .y(vb), .res(alu_res),
        .ovf_we(alu_ovf_we), .ovf(alu_ovf), .cond(alu_cond)
    );

    assign imem_addr  = pc;
    assign insn_start = fetching;
    assign dmem_we    = exec && (call || (!ext && !test_op && oa.kind == K_MEM));
    assign dmem_waddr = call ? (oa.sp_next - 1'b1) : oa.addr;
    assign dmem_wdata = call ? pc_cur : alu_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_FETCH;
            pc     <= RESET_PC;
            sp     <= RESET_SP;
            ovf    <= '0;
            ir_q   <= '0;
            nwa_q  <= '0;
            nwb_q  <= '0;
            left   <= '0;
            pend_a <= 1'b0;
            pend_b <= 1'b0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            case (st)
                ST_FETCH: begin
                    ir_q   <= imem_rdata;
                    pend_a <= need_a;
                    pend_b <= need_b;
                    left   <= cost - 1'b1;
                    pc     <= pc + 1'b1;
                    if (!last) st <= ST_RUN;
                end
                ST_RUN: begin
                    if (pend_a) begin
                        nwa_q  <= imem_rdata;
                        pend_a <= 1'b0;
                        pc     <= pc + 1'b1;
                    end else if (pend_b) begin
                        nwb_q  <= imem_rdata;
                        pend_b <= 1'b0;
                        pc     <= pc + 1'b1;
                    end
                    left <= left - 1'b1;
                    if (last) st <= ST_FETCH;
                end
                default: begin
                    // Step over the whole next instruction in one cycle
                    pc <= pc + 1'b1 + word_t'(extra_words(imem_rdata));
                    st <= ST_FETCH;
                end
            endcase

            if (exec) begin
                if (call) begin
                    sp <= oa.sp_next - 1'b1;
                    pc <= va;
                end else if (!ext) begin
                    sp <= ob.sp_next;
                    if (test_op) begin
                        if (!alu_cond) st <= ST_SKIP;
                    end else begin
                        if (alu_ovf_we) ovf <= alu_ovf;
                        case (oa.kind)
                            K_REG:   regs[oa.idx] <= alu_res;
                            K_SP:    sp  <= alu_res;
                            K_PC:    pc  <= alu_res;
                            K_OVF:   ovf <= alu_res;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (insn_start && imem_addr == RESET_PC));

    a_r5_skip_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> (!dmem_we && !insn_start));

    a_r7_literal_dest: assert property (@(posedge clk) disable iff (rst)
        (exec && !ext && !test_op && oa.kind == K_LIT) |-> !dmem_we);

    a_r6_call_target: assert property (@(posedge clk) disable iff (rst)
        (exec && call) |=> (insn_start && imem_addr == $past(va)));

    a_r10_pc_redirect: assert property (@(posedge clk) disable iff (rst)
        (exec && !ext && !test_op && oa.kind == K_PC) |=> (insn_start && imem_addr == $past(alu_res)));

    a_r3_cost_window: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (left != '0 && left <= 3'd4));

endmodule

// File: tb/cpu16_sequencer_tb.sv
module cpu16_sequencer_tb;
    import seq_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    always #5 clk = ~clk;

    word_t imem_addr, imem_rdata, dmem_raddr_a, dmem_rdata_a;
    word_t dmem_raddr_b, dmem_rdata_b, dmem_waddr, dmem_wdata;
    logic  dmem_we, insn_start;

    word_t mem [1024];
    assign imem_rdata   = mem[imem_addr[9:0]];
    assign dmem_rdata_a = mem[dmem_raddr_a[9:0]];
    assign dmem_rdata_b = mem[dmem_raddr_b[9:0]];
    always @(posedge clk) if (dmem_we) mem[dmem_waddr[9:0]] <= dmem_wdata;

    cpu16_sequencer u_dut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_raddr_a(dmem_raddr_a), .dmem_rdata_a(dmem_rdata_a),
        .dmem_raddr_b(dmem_raddr_b), .dmem_rdata_b(dmem_rdata_b),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .insn_start(insn_start)
    );

    int    checks = 0, failures = 0;
    int    fq_cyc[$], fq_pc[$], wq_addr[$], wq_data[$];
    string fq_tag[$], wq_tag[$];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input int w);
        mem[a] = word_t'(w);
    endtask

    task automatic exp_fetch(input int c, input int p, input string tag);
        fq_cyc.push_back(c); fq_pc.push_back(p); fq_tag.push_back(tag);
    endtask

    task automatic exp_write(input int a, input int d, input string tag);
        wq_addr.push_back(a); wq_data.push_back(d); wq_tag.push_back(tag);
    endtask

    task automatic load_program();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        put(16'h00, 16'h9401);                          // SET A,5
        put(16'h01, 16'h01e1); put(16'h02, 16'h0200);   // SET [0x200],A
        put(16'h03, 16'h7c02); put(16'h04, 16'hffff);   // ADD A,0xffff
        put(16'h05, 16'h75e1); put(16'h06, 16'h0201);   // SET [0x201],O
        put(16'h07, 16'h01e1); put(16'h08, 16'h0202);   // SET [0x202],A
        put(16'h09, 16'h7c04); put(16'h0a, 16'h4000);   // MUL A,0x4000
        put(16'h0b, 16'h9c11);                          // SET B,7
        put(16'h0c, 16'hf801);                          // SET A,30
        put(16'h0d, 16'h0405);                          // DIV A,B
        put(16'h0e, 16'h75e1); put(16'h0f, 16'h0203);   // SET [0x203],O
        put(16'h10, 16'h01e1); put(16'h11, 16'h0204);   // SET [0x204],A
        put(16'h12, 16'h8005);                          // DIV A,0
        put(16'h13, 16'h75e1); put(16'h14, 16'h0205);   // SET [0x205],O
        put(16'h15, 16'h840c);                          // IFE A,1 (fails)
        put(16'h16, 16'h7de1); put(16'h17, 16'h0206); put(16'h18, 16'hdead); // skipped
        put(16'h19, 16'h840d);                          // IFN A,1 (holds)
        put(16'h1a, 16'ha5e1); put(16'h1b, 16'h0207);   // SET [0x207],9
        put(16'h1c, 16'h8da1);                          // SET PUSH,3
        put(16'h1d, 16'h7c10); put(16'h1e, 16'h0030);   // call 0x30
        put(16'h30, 16'h61e1); put(16'h31, 16'h0208);   // SET [0x208],POP
        put(16'h32, 16'h61e1); put(16'h33, 16'h0209);   // SET [0x209],POP
        put(16'h34, 16'h05f1); put(16'h35, 16'h1234);   // SET literal 0x1234,B
        put(16'h36, 16'h9017);                          // SHL B,4
        put(16'h37, 16'ha018);                          // SHR B,8
        put(16'h38, 16'h75e1); put(16'h39, 16'h020a);   // SET [0x20a],O
        put(16'h3a, 16'h8423);                          // SUB C,1
        put(16'h3b, 16'h75e1); put(16'h3c, 16'h020b);   // SET [0x20b],O
        put(16'h3d, 16'h8020);                          // reserved extended op
        put(16'h3e, 16'h7dc1); put(16'h3f, 16'h003e);   // SET PC,0x3e
    endtask

    task automatic drive_expectations();
        exp_fetch(0,  16'h00, "R1");  exp_fetch(1,  16'h01, "R3");
        exp_fetch(3,  16'h03, "R4");  exp_fetch(6,  16'h05, "R3");
        exp_fetch(8,  16'h07, "R4");  exp_fetch(10, 16'h09, "R4");
        exp_fetch(13, 16'h0b, "R3");  exp_fetch(14, 16'h0c, "R3");
        exp_fetch(15, 16'h0d, "R3");  exp_fetch(18, 16'h0e, "R3");
        exp_fetch(20, 16'h10, "R4");  exp_fetch(22, 16'h12, "R4");
        exp_fetch(25, 16'h13, "R3");  exp_fetch(27, 16'h15, "R4");
        exp_fetch(30, 16'h19, "R5");  exp_fetch(32, 16'h1a, "R5");
        exp_fetch(34, 16'h1c, "R4");  exp_fetch(35, 16'h1d, "R9");
        exp_fetch(38, 16'h30, "R6");  exp_fetch(40, 16'h32, "R4");
        exp_fetch(42, 16'h34, "R4");  exp_fetch(44, 16'h36, "R7");
        exp_fetch(46, 16'h37, "R3");  exp_fetch(48, 16'h38, "R3");
        exp_fetch(50, 16'h3a, "R4");  exp_fetch(52, 16'h3b, "R3");
        exp_fetch(54, 16'h3d, "R4");  exp_fetch(55, 16'h3e, "R11");
        exp_fetch(57, 16'h3e, "R10"); exp_fetch(59, 16'h3e, "R10");

        exp_write(16'h0200, 16'h0005, "R2");
        exp_write(16'h0201, 16'h0001, "R8");
        exp_write(16'h0202, 16'h0004, "R8");
        exp_write(16'h0203, 16'h4924, "R8");
        exp_write(16'h0204, 16'h0004, "R8");
        exp_write(16'h0205, 16'h0000, "R8");
        exp_write(16'h0207, 16'h0009, "R5");
        exp_write(16'hffff, 16'h0003, "R9");
        exp_write(16'hfffe, 16'h001f, "R6");
        exp_write(16'h0208, 16'h001f, "R9");
        exp_write(16'h0209, 16'h0003, "R9");
        exp_write(16'h020a, 16'h7000, "R8");
        exp_write(16'h020b, 16'hffff, "R8");
    endtask

    task automatic monitor();
        for (int k = 0; k < 62; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            if (insn_start && fq_cyc.size() > 0) begin
                int    c  = fq_cyc.pop_front();
                int    p  = fq_pc.pop_front();
                string tg = fq_tag.pop_front();
                check(k == c, tg, "fetch cycle", k, c);
                check(int'(imem_addr) == p, tg, "fetch address", int'(imem_addr), p);
            end
            if (dmem_we) begin
                if (wq_addr.size() == 0) begin
                    check(1'b0, "R5/R7/R11", "unexpected write address", int'(dmem_waddr), 0);
                end else begin
                    int    a  = wq_addr.pop_front();
                    int    d  = wq_data.pop_front();
                    string tg = wq_tag.pop_front();
                    check(int'(dmem_waddr) == a, tg, "write address", int'(dmem_waddr), a);
                    check(int'(dmem_wdata) == d, tg, "write data", int'(dmem_wdata), d);
                end
            end
        end
    endtask

    initial begin
        bit timed_out = 1'b0;
        load_program();
        drive_expectations();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(insn_start == 1'b1, "R1", "insn_start in reset", int'(insn_start), 1);
        check(imem_addr == 16'h0, "R1", "imem_addr in reset", int'(imem_addr), 0);
        check(dmem_we == 1'b0, "R1", "dmem_we in reset", int'(dmem_we), 0);
        rst = 1'b0;
        fork
            monitor();
            begin
                repeat (2000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) check(1'b0, "R3", "watchdog expired", 1, 0);
        check(fq_cyc.size() == 0, "R3", "fetches left unseen", fq_cyc.size(), 0);
        check(wq_addr.size() == 0, "R9", "writes left unseen", wq_addr.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule